// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is the system control register that a small microcontroller core writes to select its clocking and to enter low-power states. It is one byte wide. It holds enables for the fast and slow oscillators and a system clock select. It also holds two request bits. The first stops the CPU and watchdog clocks, giving the idle mode or the sleep-1 mode. The second stops every peripheral clock except the time-base timer, giving the idle-0 mode or the sleep-0 mode.

A one-cycle wake-up pulse from the interrupt logic ends whichever low-power state is active. The pulse clears the request bit that caused that state, so the gated clocks run again from the next cycle. The block also reports the current operating mode as a 3-bit code.

It steers the input source of stage 9 of the divider chain. When the slow clock is the system clock, stage 9 always takes the slow clock, whatever the divider's own preference is.

Everything is in one clock domain. The oscillators, the clock multiplexers and the divider appear only as enable and select lines.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, rd_data reads 0x40: the fast oscillator is enabled and every other bit is 0. The CPU, watchdog and peripheral clock enables are 1 and mode is 0.
- R2: A write loads bit 6 (fast oscillator enable), bit 5 (slow oscillator enable) and bit 4 (clock select, 1 = slow clock divided by 4) at the next clock edge. Bits 7, 1 and 0 always read 0, whatever value was written to them.
- R3: While register bit 3 (idle request) is 1, cpu_clk_en and wdt_clk_en are 0. While bit 3 is 0, both are 1. A write takes effect at the next edge.
- R4: While register bit 2 (halt request) is 1, periph_clk_en is 0. Bit 2 does not change cpu_clk_en or wdt_clk_en.
- R5: A write with data bits 3 and 2 both at 1 leaves register bits 3 and 2 at their previous values. The same write still loads bits 6, 5 and 4.
- R6: A wake pulse clears register bits 3 and 2 at the next edge, so the gated enables return to 1 on the next cycle. A wake pulse takes priority over a write to those bits in the same cycle.
- R7: mode encodes the operating mode as follows. 0 is normal (select 0, no request) and 1 is slow (select 1, no request). 2 is idle (select 0, bit 3) and 3 is idle-0 (select 0, bit 2). 4 is sleep-1 (select 1, bit 3) and 5 is sleep-0 (select 1, bit 2).
- R8: stage9_lowclk is 1 whenever register bit 4 is 1. Otherwise it follows stage9_lowclk_req in the same cycle.
- R9: Register bits 3 and 2 are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data byte |
| wake | input | 1 | One-cycle wake-up pulse |
| stage9_lowclk_req | input | 1 | Divider's own stage 9 source preference (1 = slow clock) |
| rd_data | output | 8 | Register read value |
| hosc_en | output | 1 | Fast oscillator enable |
| losc_en | output | 1 | Slow oscillator enable |
| clk_sel | output | 1 | System clock select (1 = slow clock / 4) |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable (time-base timer excluded) |
| stage9_lowclk | output | 1 | Stage 9 source select (1 = slow clock) |
| mode | output | 3 | Operating mode code |

## Verification
All register-held results are due one clock edge after the write or wake that causes them. These are rd_data, the oscillator and clock enables, clk_sel and mode. stage9_lowclk is due in the same cycle as its input, because it is combinational. The bench drives stimulus on the falling edge and lets one rising edge pass. It then updates its reference model and compares every output on the next falling edge, so each check sees exactly one edge of latency. The only same-cycle result, the stage 9 select, is compared against the input still being driven.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wake,
  input  logic       stage9_lowclk_req,
  output logic [7:0] rd_data,
  output logic       hosc_en,
  output logic       losc_en,
  output logic       clk_sel,
  output logic       cpu_clk_en,
  output logic       wdt_clk_en,
  output logic       periph_clk_en,
  output logic       stage9_lowclk,
  output logic [2:0] mode
);

  localparam int B_HOSC = 6;
  localparam int B_LOSC = 5;
  localparam int B_SEL  = 4;
  localparam int B_IDLE = 3;
  localparam int B_HALT = 2;
  localparam logic [7:0] RST_VAL = 8'h40;
  localparam logic [7:0] WMASK   = 8'h7C;
  localparam logic [7:0] REQ     = 8'h0C;

  typedef enum logic [2:0] {
    M_NORMAL = 3'd0,
    M_SLOW   = 3'd1,
    M_IDLE   = 3'd2,
    M_IDLE0  = 3'd3,
    M_SLEEP1 = 3'd4,
    M_SLEEP0 = 3'd5
  } mode_e;

  logic [7:0] ctl_q, ctl_d, wr_val;
  logic       both_req;
  mode_e      mode_c;

  assign both_req = wr_data[B_IDLE] & wr_data[B_HALT];

  always_comb begin
    ctl_d  = ctl_q;
    wr_val = wr_data & WMASK;
    if (both_req) wr_val = (wr_val & ~REQ) | (ctl_q & REQ);
    if (wr_en) ctl_d = wr_val;
    if (wake)  ctl_d = ctl_d & ~REQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= RST_VAL;
    else        ctl_q <= ctl_d;
  end

  assign rd_data       = ctl_q & WMASK;
  assign hosc_en       = ctl_q[B_HOSC];
  assign losc_en       = ctl_q[B_LOSC];
  assign clk_sel       = ctl_q[B_SEL];
  assign cpu_clk_en    = ~ctl_q[B_IDLE];
  assign wdt_clk_en    = ~ctl_q[B_IDLE];
  assign periph_clk_en = ~ctl_q[B_HALT];
  assign stage9_lowclk = ctl_q[B_SEL] | stage9_lowclk_req;

  always_comb begin
    case ({ctl_q[B_SEL], ctl_q[B_IDLE], ctl_q[B_HALT]})
      3'b000:  mode_c = M_NORMAL;
      3'b100:  mode_c = M_SLOW;
      3'b010:  mode_c = M_IDLE;
      3'b001:  mode_c = M_IDLE0;
      3'b110:  mode_c = M_SLEEP1;
      3'b101:  mode_c = M_SLEEP0;
      default: mode_c = M_NORMAL;
    endcase
  end
  assign mode = mode_c;

  assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_q[B_IDLE] && ctl_q[B_HALT]));

  assert_wake_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (cpu_clk_en && wdt_clk_en && periph_clk_en));

  assert_both_set_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_IDLE] && wr_data[B_HALT] && !wake)
      |=> (cpu_clk_en == $past(cpu_clk_en) && periph_clk_en == $past(periph_clk_en)));

  assert_idle_gates_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_IDLE] && !wr_data[B_HALT] && !wake)
      |=> (!cpu_clk_en && !wdt_clk_en && periph_clk_en));

  assert_halt_spares_cpu_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_HALT] && !wr_data[B_IDLE] && !wake)
      |=> (!periph_clk_en && cpu_clk_en && wdt_clk_en));

  assert_osc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (hosc_en == $past(wr_data[B_HOSC]) && losc_en == $past(wr_data[B_LOSC])
               && clk_sel == $past(wr_data[B_SEL])));

endmodule

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wake = 1'b0;
  logic       s9_req = 1'b0;
  logic [7:0] rd_data;
  logic       hosc_en, losc_en, clk_sel, cpu_clk_en, wdt_clk_en, periph_clk_en, stage9_lowclk;
  logic [2:0] mode;

  int errors = 0;
  int checks = 0;
  logic m_hosc, m_losc, m_sel, m_idle, m_halt;

  always #5 clk = ~clk;

  pwr_mode_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wake(wake),
    .stage9_lowclk_req(s9_req), .rd_data(rd_data), .hosc_en(hosc_en),
    .losc_en(losc_en), .clk_sel(clk_sel), .cpu_clk_en(cpu_clk_en),
    .wdt_clk_en(wdt_clk_en), .periph_clk_en(periph_clk_en),
    .stage9_lowclk(stage9_lowclk), .mode(mode)
  );

  function automatic logic [7:0] exp_rd();
    return {1'b0, m_hosc, m_losc, m_sel, m_idle, m_halt, 2'b00};
  endfunction

  function automatic logic [2:0] exp_mode();
    if (m_idle) return m_sel ? 3'd4 : 3'd2;
    if (m_halt) return m_sel ? 3'd5 : 3'd3;
    return m_sel ? 3'd1 : 3'd0;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(rd_data, exp_rd(), "R2 rd_data");
    chk({7'd0, hosc_en}, {7'd0, m_hosc}, "R2 hosc_en");
    chk({7'd0, losc_en}, {7'd0, m_losc}, "R2 losc_en");
    chk({7'd0, clk_sel}, {7'd0, m_sel}, "R2 clk_sel");
    chk({6'd0, cpu_clk_en, wdt_clk_en}, {6'd0, ~m_idle, ~m_idle}, "R3 cpu/wdt enables");
    chk({7'd0, periph_clk_en}, {7'd0, ~m_halt}, "R4 periph_clk_en");
    chk({5'd0, mode}, {5'd0, exp_mode()}, "R7 mode");
    chk({7'd0, stage9_lowclk}, {7'd0, m_sel | s9_req}, "R8 stage9_lowclk");
    chk({7'd0, m_idle & m_halt}, 8'd0, "R9 model exclusivity");
  endtask

  task automatic cycle(input logic w, input logic [7:0] d, input logic k, input logic s);
    wr_en = w; wr_data = d; wake = k; s9_req = s;
    @(posedge clk);
    if (w) begin
      m_hosc = d[6]; m_losc = d[5]; m_sel = d[4];
      if (!(d[3] && d[2])) begin m_idle = d[3]; m_halt = d[2]; end
    end
    if (k) begin m_idle = 1'b0; m_halt = 1'b0; end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_hosc = 1'b1; m_losc = 1'b0; m_sel = 1'b0; m_idle = 1'b0; m_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_data, 8'h40, "R1 reset rd_data");
    chk({5'd0, mode}, 8'd0, "R1 reset mode");
    chk({5'd0, cpu_clk_en, wdt_clk_en, periph_clk_en}, 8'h07, "R1 reset enables");
    // R2 reserved bits read 0
    cycle(1'b1, 8'hA3, 1'b0, 1'b0);
    chk(rd_data, 8'h20, "R2 reserved bits");
    // R3 idle entry then R6 wake
    cycle(1'b1, 8'h48, 1'b0, 1'b0);
    chk({7'd0, cpu_clk_en}, 8'd0, "R3 idle stops cpu");
    // R5 both set while idle: request bits kept, others loaded
    cycle(1'b1, 8'h7C, 1'b0, 1'b0);
    chk(rd_data, 8'h78, "R5 both-set write ignored");
    cycle(1'b0, 8'h00, 1'b1, 1'b0);
    chk({7'd0, cpu_clk_en}, 8'd1, "R6 wake restores cpu");
    // R4 halt with slow select: sleep-0
    cycle(1'b1, 8'h74, 1'b0, 1'b0);
    chk({5'd0, mode}, 8'd5, "R7 sleep-0 code");
    chk({6'd0, cpu_clk_en, periph_clk_en}, 8'h02, "R4 halt spares cpu");
    // R6 wake wins over simultaneous request write
    cycle(1'b1, 8'h48, 1'b1, 1'b1);
    chk(rd_data, 8'h40, "R6 wake beats write");
    // R8 stage9 follows request when fast select
    cycle(1'b0, 8'h00, 1'b0, 1'b0);
    chk({7'd0, stage9_lowclk}, 8'd0, "R8 stage9 follows request");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cycle(r[8], r[7:0], (r[11:9] == 3'd0), r[12]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule